// File: doc/BRIEF.md
# Interrupt Controller Register Access Sequencer

This block is the front end of a single eight-line interrupt controller. It takes byte-wide reads and writes on a two-address register port, where the address bit selects the command port (0) or the data port (1). It classifies each command-port write as an initialization start, a status/mode control word or an end-of-service command. It runs the initialization word sequence through the data port, and loads the mask register from that same port once initialization is complete.

Writes produce configuration values and single-cycle strobes for the neighbouring priority resolver and request latch. These are the mask, the vector base, the auto-acknowledge and nested-mode flags, the special-mask flag, an initialization strobe that tells the latch to clear and drop its output, and a forwarded command byte. Reads return the request or in-service vector, the mask, or a poll result. A poll result turns the read into an acknowledge of the line the resolver currently offers. The acknowledge vector is formed from the stored base and the line number the resolver supplies.

Top module: `pic_reg_sequencer`

## Requirements
- R1: After reset the mask is 0x00, the vector base is 0x00, the auto-acknowledge, nested-mode and special-mask flags are 0, `init_busy` is 0, poll is disarmed, and status reads at address 0 return the request vector `irr_in`.
- R2: A selected write at address 0 with bit 4 set pulses `init_strobe` in that cycle. From the next cycle `init_busy` is 1, and the mask, vector base, auto-acknowledge, nested-mode and special-mask flags are 0. Status reads return `irr_in` and poll is disarmed. Bit 0 of the word records whether a fourth word will follow.
- R3: The first data-port write after an initialization start stores the byte with bits 2..0 cleared as `vec_base` and leaves `imr` unchanged.
- R4: The second data-port write of the sequence ends initialization (`init_busy` 0) when the fourth-word flag is 0, and otherwise keeps `init_busy` at 1 awaiting the fourth word.
- R5: The fourth word sets `nested_mode` from its bit 4 and `auto_eoi` from its bit 1, and ends initialization.
- R6: A selected data-port write outside initialization loads `imr` with the byte.
- R7: A write at address 0 with bit 4 clear and bit 3 set is a control word. Bit 2 = 1 arms poll. When bit 1 = 1, bit 0 selects the status read source (1 = in-service, 0 = request); when bit 1 = 0 the selection is kept. When bit 6 = 1, bit 5 sets `special_mask`; when bit 6 = 0 that flag is kept.
- R8: A write at address 0 with bits 4 and 3 both clear pulses `cmd_strobe` for one cycle with `cmd_data` equal to the byte, and changes no configuration value.
- R9: A read at address 0 returns the selected status vector, and a read at address 1 returns `imr`. `rdata` is 0x00 whenever no selected read is active.
- R10: The first read after poll is armed returns the resolver's `best_line` zero-extended when `best_valid` is 1, and pulses `poll_clear` with `poll_line` equal to that line. It returns 0x07 with no `poll_clear` when `best_valid` is 0. Poll is then disarmed.
- R11: `ack_vector` equals `vec_base` plus `ack_line`.
- R12: A read and a write in the same cycle share the address. The read returns the state before the write, and a control word with bit 2 set written during a poll read leaves poll armed for the following read.
- R13: With `sel` low, reads and writes have no effect: no strobes, no poll clear, no register change, and `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chip select qualifying both strobes |
| wr_en | input | 1 | Write strobe (one byte per cycle) |
| rd_en | input | 1 | Read strobe (one byte per cycle) |
| addr | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid in the read cycle |
| irr_in | input | 8 | Request vector from the latch |
| isr_in | input | 8 | In-service vector from the latch |
| best_valid | input | 1 | Resolver has a line to offer |
| best_line | input | 3 | Line offered by the resolver |
| ack_line | input | 3 | Line being acknowledged |
| ack_vector | output | 8 | Vector base plus acknowledged line |
| imr | output | 8 | Mask register |
| vec_base | output | 8 | Vector base, bits 2..0 zero |
| auto_eoi | output | 1 | Auto-acknowledge mode flag |
| nested_mode | output | 1 | Special fully nested mode flag |
| special_mask | output | 1 | Special mask mode flag |
| init_strobe | output | 1 | Initialization start; latch clears and drops its output |
| cmd_strobe | output | 1 | End-of-service / rotation command present |
| cmd_data | output | 8 | Forwarded command byte, 0 when no command |
| poll_clear | output | 1 | Clear request and in-service bits of `poll_line` |
| poll_line | output | 3 | Line cleared by a poll read |
| init_busy | output | 1 | Initialization sequence in progress |

## Verification
Two functions meet in a single cycle when a read and a write are issued together on the shared address. This happens when a mask load coincides with a mask read, and when a poll-arming control word coincides with a poll read. The bench raises both strobes in one cycle. It judges that the returned byte reflects the old mask or the poll result, and that the register update and the re-armed poll show up only from the next cycle. A further read then confirms that poll was consumed exactly once after that.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;

  // Data-port sequence position
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_e;

  // Command-port word classification bits
  localparam int unsigned B_INIT    = 4;
  localparam int unsigned B_CTRL    = 3;
  // Control word fields
  localparam int unsigned B_POLL    = 2;
  localparam int unsigned B_RSEL_EN = 1;
  localparam int unsigned B_RSEL    = 0;
  localparam int unsigned B_SMM_EN  = 6;
  localparam int unsigned B_SMM     = 5;
  // Initialization word fields
  localparam int unsigned B_NEED4   = 0;
  localparam int unsigned B_NEST    = 4;
  localparam int unsigned B_AEOI    = 1;

endpackage

// File: rtl/pic_seq_decode.sv
module pic_seq_decode #(
  parameter int DATA_W = 8
) (
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ev_init,
  output logic              ev_ctrl,
  output logic              ev_cmd,
  output logic              ev_data,
  output logic              ev_rd
);
  import pic_seq_pkg::*;

  logic wr_go;
  logic cmd_port;

  assign wr_go    = sel & wr_en;
  assign cmd_port = wr_go & ~addr;

  assign ev_init = cmd_port & wdata[B_INIT];
  assign ev_ctrl = cmd_port & ~wdata[B_INIT] & wdata[B_CTRL];
  assign ev_cmd  = cmd_port & ~wdata[B_INIT] & ~wdata[B_CTRL];
  assign ev_data = wr_go & addr;
  assign ev_rd   = sel & rd_en;

endmodule

// File: rtl/pic_seq_init_fsm.sv
module pic_seq_init_fsm #(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_init,
  input  logic                  ev_data,
  input  logic [DATA_W-1:0]     wdata,
  output pic_seq_pkg::init_st_e st,
  output logic [DATA_W-1:0]     imr,
  output logic [DATA_W-1:0]     vec_base,
  output logic                  auto_eoi,
  output logic                  nested_mode
);
  import pic_seq_pkg::*;

  logic need4;

  // Aligns a byte to a vector-table boundary
  function automatic logic [DATA_W-1:0] base_of(input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] m;
    m = '1;
    m[LINE_W-1:0] = '0;
    return b & m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      need4       <= 1'b0;
      imr         <= '0;
      vec_base    <= '0;
      auto_eoi    <= 1'b0;
      nested_mode <= 1'b0;
    end else if (ev_init) begin
      st          <= ST_BASE;
      need4       <= wdata[B_NEED4];
      imr         <= '0;
      vec_base    <= '0;
      auto_eoi    <= 1'b0;
      nested_mode <= 1'b0;
    end else if (ev_data) begin
      unique case (st)
        ST_IDLE: imr <= wdata;
        ST_BASE: begin
          vec_base <= base_of(wdata);
          st       <= ST_CASC;
        end
        ST_CASC: st <= need4 ? ST_MODE : ST_IDLE;
        ST_MODE: begin
          nested_mode <= wdata[B_NEST];
          auto_eoi    <= wdata[B_AEOI];
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pic_seq_ctrl.sv
module pic_seq_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_init,
  input  logic              ev_ctrl,
  input  logic              ev_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic              poll_q,
  output logic              rsel_q,
  output logic              smm_q
);
  import pic_seq_pkg::*;

  logic arm;
  logic take;

  assign arm  = ev_ctrl & wdata[B_POLL];
  assign take = ev_rd & poll_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= 1'b0;
      rsel_q <= 1'b0;
      smm_q  <= 1'b0;
    end else if (ev_init) begin
      poll_q <= 1'b0;
      rsel_q <= 1'b0;
      smm_q  <= 1'b0;
    end else begin
      if (arm)       poll_q <= 1'b1;
      else if (take) poll_q <= 1'b0;
      if (ev_ctrl && wdata[B_RSEL_EN]) rsel_q <= wdata[B_RSEL];
      if (ev_ctrl && wdata[B_SMM_EN])  smm_q  <= wdata[B_SMM];
    end
  end

endmodule

// File: rtl/pic_seq_readback.sv
module pic_seq_readback #(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3
) (
  input  logic              ev_rd,
  input  logic              addr,
  input  logic              poll_q,
  input  logic              rsel_q,
  input  logic [DATA_W-1:0] irr_in,
  input  logic [DATA_W-1:0] isr_in,
  input  logic [DATA_W-1:0] imr,
  input  logic              best_valid,
  input  logic [LINE_W-1:0] best_line,
  output logic [DATA_W-1:0] rdata,
  output logic              poll_clear,
  output logic [LINE_W-1:0] poll_line
);

  localparam logic [LINE_W-1:0] NO_LINE = '1;

  function automatic logic [DATA_W-1:0] widen(input logic [LINE_W-1:0] l);
    return DATA_W'(l);
  endfunction

  always_comb begin
    rdata      = '0;
    poll_clear = 1'b0;
    poll_line  = best_line;
    if (ev_rd) begin
      if (poll_q) begin
        poll_clear = best_valid;
        rdata      = best_valid ? widen(best_line) : widen(NO_LINE);
      end else if (addr) begin
        rdata = imr;
      end else begin
        rdata = rsel_q ? isr_in : irr_in;
      end
    end
  end

endmodule

// File: rtl/pic_reg_sequencer.sv
module pic_reg_sequencer #(
  parameter int DATA_W = 8,
  parameter int LINES  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic                      addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  input  logic [DATA_W-1:0]         irr_in,
  input  logic [DATA_W-1:0]         isr_in,
  input  logic                      best_valid,
  input  logic [$clog2(LINES)-1:0]  best_line,
  input  logic [$clog2(LINES)-1:0]  ack_line,
  output logic [DATA_W-1:0]         ack_vector,
  output logic [DATA_W-1:0]         imr,
  output logic [DATA_W-1:0]         vec_base,
  output logic                      auto_eoi,
  output logic                      nested_mode,
  output logic                      special_mask,
  output logic                      init_strobe,
  output logic                      cmd_strobe,
  output logic [DATA_W-1:0]         cmd_data,
  output logic                      poll_clear,
  output logic [$clog2(LINES)-1:0]  poll_line,
  output logic                      init_busy
);
  import pic_seq_pkg::*;

  localparam int LINE_W = $clog2(LINES);

  // Named internal events
  logic     ev_init;
  logic     ev_ctrl;
  logic     ev_cmd;
  logic     ev_data;
  logic     ev_rd;
  logic     poll_q;
  logic     rsel_q;
  init_st_e st;

  function automatic logic [DATA_W-1:0] vec_of(input logic [DATA_W-1:0] base,
                                               input logic [LINE_W-1:0] line);
    return base + DATA_W'(line);
  endfunction

  pic_seq_decode #(.DATA_W(DATA_W)) u_dec (
    .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .ev_init(ev_init), .ev_ctrl(ev_ctrl), .ev_cmd(ev_cmd),
    .ev_data(ev_data), .ev_rd(ev_rd)
  );

  pic_seq_init_fsm #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_init (
    .clk(clk), .rst_n(rst_n), .ev_init(ev_init), .ev_data(ev_data),
    .wdata(wdata), .st(st), .imr(imr), .vec_base(vec_base),
    .auto_eoi(auto_eoi), .nested_mode(nested_mode)
  );

  pic_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_init(ev_init), .ev_ctrl(ev_ctrl),
    .ev_rd(ev_rd), .wdata(wdata), .poll_q(poll_q), .rsel_q(rsel_q),
    .smm_q(special_mask)
  );

  pic_seq_readback #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_rd (
    .ev_rd(ev_rd), .addr(addr), .poll_q(poll_q), .rsel_q(rsel_q),
    .irr_in(irr_in), .isr_in(isr_in), .imr(imr),
    .best_valid(best_valid), .best_line(best_line),
    .rdata(rdata), .poll_clear(poll_clear), .poll_line(poll_line)
  );

  assign init_strobe = ev_init;
  assign cmd_strobe  = ev_cmd;
  assign cmd_data    = ev_cmd ? wdata : '0;
  assign init_busy   = (st != ST_IDLE);
  assign ack_vector  = vec_of(vec_base, ack_line);

endmodule

// File: rtl/pic_reg_sequencer_chk.sv
module pic_reg_sequencer_chk #(
  parameter int DATA_W = 8,
  parameter int LINES  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sel,
  input logic [DATA_W-1:0]        wdata,
  input logic [DATA_W-1:0]        rdata,
  input logic [DATA_W-1:0]        imr,
  input logic [DATA_W-1:0]        vec_base,
  input logic                     auto_eoi,
  input logic                     nested_mode,
  input logic                     special_mask,
  input logic                     init_strobe,
  input logic                     cmd_strobe,
  input logic                     poll_clear,
  input logic [$clog2(LINES)-1:0] poll_line,
  input logic [$clog2(LINES)-1:0] best_line,
  input logic                     init_busy,
  input pic_seq_pkg::init_st_e    st,
  input logic                     ev_data,
  input logic                     ev_rd,
  input logic                     ev_ctrl,
  input logic                     poll_q
);
  import pic_seq_pkg::*;

  localparam logic [DATA_W-1:0] ALIGN = ~DATA_W'(LINES - 1);

  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_strobe |=> init_busy && imr == '0 && vec_base == '0 && !auto_eoi
                    && !nested_mode && !special_mask && !poll_q);

  p_base_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data && st == ST_BASE) |=> vec_base == ($past(wdata) & ALIGN) && $stable(imr));

  p_mode_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data && st == ST_MODE) |=> !init_busy && auto_eoi == $past(wdata[B_AEOI])
                                   && nested_mode == $past(wdata[B_NEST]));

  p_imr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data && st == ST_IDLE) |=> imr == $past(wdata));

  p_cmd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> $stable(imr) && $stable(vec_base) && $stable(special_mask)
                   && $stable(init_busy));

  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rd |-> rdata == '0);

  p_poll_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_clear |-> poll_q && ev_rd && poll_line == best_line
                   && rdata == DATA_W'(poll_line));

  p_poll_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd && poll_q && !ev_ctrl) |=> !poll_q);

  p_sel_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !init_strobe && !cmd_strobe && !poll_clear && !ev_data && !ev_rd);

endmodule

bind pic_reg_sequencer pic_reg_sequencer_chk #(.DATA_W(DATA_W), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wdata(wdata), .rdata(rdata),
  .imr(imr), .vec_base(vec_base), .auto_eoi(auto_eoi),
  .nested_mode(nested_mode), .special_mask(special_mask),
  .init_strobe(init_strobe), .cmd_strobe(cmd_strobe),
  .poll_clear(poll_clear), .poll_line(poll_line), .best_line(best_line),
  .init_busy(init_busy), .st(st), .ev_data(ev_data), .ev_rd(ev_rd),
  .ev_ctrl(ev_ctrl), .poll_q(poll_q)
);

// File: tb/pic_reg_sequencer_test.sv
module pic_reg_sequencer_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, wr_en, rd_en, addr;
  logic [7:0] wdata, rdata, irr_in, isr_in;
  logic       best_valid;
  logic [2:0] best_line, ack_line;
  logic [7:0] ack_vector, imr, vec_base, cmd_data;
  logic       auto_eoi, nested_mode, special_mask;
  logic       init_strobe, cmd_strobe, poll_clear, init_busy;
  logic [2:0] poll_line;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_reg_sequencer uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irr_in(irr_in),
    .isr_in(isr_in), .best_valid(best_valid), .best_line(best_line),
    .ack_line(ack_line), .ack_vector(ack_vector), .imr(imr),
    .vec_base(vec_base), .auto_eoi(auto_eoi), .nested_mode(nested_mode),
    .special_mask(special_mask), .init_strobe(init_strobe),
    .cmd_strobe(cmd_strobe), .cmd_data(cmd_data), .poll_clear(poll_clear),
    .poll_line(poll_line), .init_busy(init_busy)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // Drive one access at the falling edge; combinational outputs valid after #1
  task automatic cyc_begin(input logic s, input logic w, input logic r,
                           input logic a, input logic [7:0] d);
    @(negedge clk);
    sel = s; wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
  endtask

  // Return to idle; registered results of the previous access are visible
  task automatic cyc_end();
    @(negedge clk);
    sel = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 8'h00;
    #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    cyc_begin(1, 1, 0, a, d);
    cyc_end();
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string what);
    cyc_begin(1, 0, 1, a, 8'h00);
    chk(what, rdata, exp);
    cyc_end();
  endtask

  task automatic t_reset();
    chk("R1 imr", imr, 8'h00);
    chk("R1 vec_base", vec_base, 8'h00);
    chk("R1 flags", {auto_eoi, nested_mode, special_mask, init_busy}, 4'b0000);
    chk("R9 R13 rdata idle", rdata, 8'h00);
    rd_chk(0, 8'h55, "R1 status read is irr");
    rd_chk(0, 8'h55, "R1 poll disarmed");
  endtask

  task automatic t_init_full();
    cyc_begin(1, 1, 0, 0, 8'h11);
    chk("R2 init_strobe", init_strobe, 1);
    chk("R2 no cmd_strobe", cmd_strobe, 0);
    cyc_end();
    chk("R2 busy", init_busy, 1);
    wr(1, 8'h4D);
    chk("R3 base aligned", vec_base, 8'h48);
    chk("R3 imr untouched", imr, 8'h00);
    wr(1, 8'hFF);
    chk("R4 waits for fourth word", init_busy, 1);
    wr(1, 8'h12);
    chk("R5 nested", nested_mode, 1);
    chk("R5 auto_eoi", auto_eoi, 1);
    chk("R5 done", init_busy, 0);
    ack_line = 3'd5;
    #1;
    chk("R11 ack_vector", ack_vector, 8'h4D);
  endtask

  task automatic t_init_short();
    wr(1, 8'hA5);
    chk("R6 imr load", imr, 8'hA5);
    rd_chk(1, 8'hA5, "R9 imr read");
    wr(0, 8'h0B);
    wr(0, 8'h68);
    wr(0, 8'h10);
    chk("R2 imr cleared", imr, 8'h00);
    chk("R2 flags cleared", {auto_eoi, nested_mode, special_mask}, 3'b000);
    chk("R2 base cleared", vec_base, 8'h00);
    rd_chk(0, 8'h55, "R2 read select back to irr");
    wr(1, 8'h27);
    chk("R3 base", vec_base, 8'h20);
    wr(1, 8'h00);
    chk("R4 no fourth word", init_busy, 0);
    wr(1, 8'h3C);
    chk("R6 imr after init", imr, 8'h3C);
    chk("R6 auto_eoi unchanged", auto_eoi, 0);
    ack_line = 3'd7;
    #1;
    chk("R11 ack_vector top line", ack_vector, 8'h27);
  endtask

  task automatic t_ctrl();
    wr(0, 8'h0B);
    rd_chk(0, 8'h0A, "R7 select isr");
    wr(0, 8'h08);
    rd_chk(0, 8'h0A, "R7 select kept");
    wr(0, 8'h0A);
    rd_chk(0, 8'h55, "R7 select irr");
    wr(0, 8'h68);
    chk("R7 smm set", special_mask, 1);
    wr(0, 8'h28);
    chk("R7 smm kept", special_mask, 1);
    wr(0, 8'h48);
    chk("R7 smm clear", special_mask, 0);
    rd_chk(1, 8'h3C, "R9 imr read");
  endtask

  task automatic t_cmd();
    cyc_begin(1, 1, 0, 0, 8'h20);
    chk("R8 cmd_strobe", cmd_strobe, 1);
    chk("R8 cmd_data", cmd_data, 8'h20);
    cyc_end();
    chk("R8 strobe one cycle", cmd_strobe, 0);
    chk("R8 cmd_data idle", cmd_data, 8'h00);
    cyc_begin(1, 1, 0, 0, 8'hE3);
    chk("R8 cmd_data second", cmd_data, 8'hE3);
    chk("R8 no init", init_strobe, 0);
    cyc_end();
    chk("R8 imr kept", imr, 8'h3C);
    chk("R8 base kept", vec_base, 8'h20);
    chk("R8 not busy", init_busy, 0);
  endtask

  task automatic t_poll();
    wr(0, 8'h0C);
    best_valid = 1; best_line = 3'd3;
    cyc_begin(1, 0, 1, 1, 8'h00);
    chk("R10 poll data", rdata, 8'h03);
    chk("R10 poll_clear", poll_clear, 1);
    chk("R10 poll_line", poll_line, 3'd3);
    cyc_end();
    cyc_begin(1, 0, 1, 0, 8'h00);
    chk("R10 disarmed read", rdata, 8'h55);
    chk("R10 no clear after", poll_clear, 0);
    cyc_end();
    wr(0, 8'h0C);
    best_valid = 0;
    cyc_begin(1, 0, 1, 0, 8'h00);
    chk("R10 empty poll", rdata, 8'h07);
    chk("R10 empty no clear", poll_clear, 0);
    cyc_end();
    rd_chk(0, 8'h55, "R10 disarmed after empty");
  endtask

  task automatic t_same_cycle();
    cyc_begin(1, 1, 1, 1, 8'h99);
    chk("R12 read sees old imr", rdata, 8'h3C);
    cyc_end();
    chk("R12 imr updated", imr, 8'h99);
    wr(0, 8'h0C);
    best_valid = 1; best_line = 3'd6;
    cyc_begin(1, 1, 1, 0, 8'h0C);
    chk("R12 poll result", rdata, 8'h06);
    chk("R12 poll_clear", poll_clear, 1);
    cyc_end();
    best_valid = 0;
    rd_chk(0, 8'h07, "R12 poll re-armed");
    rd_chk(0, 8'h55, "R12 poll consumed once");
  endtask

  task automatic t_nosel();
    cyc_begin(0, 1, 0, 0, 8'h11);
    chk("R13 no init_strobe", init_strobe, 0);
    cyc_end();
    chk("R13 not busy", init_busy, 0);
    cyc_begin(0, 1, 0, 0, 8'h20);
    chk("R13 no cmd_strobe", cmd_strobe, 0);
    cyc_end();
    cyc_begin(0, 1, 0, 1, 8'h00);
    cyc_end();
    chk("R13 imr kept", imr, 8'h99);
    wr(0, 8'h0C);
    best_valid = 1; best_line = 3'd2;
    cyc_begin(0, 0, 1, 0, 8'h00);
    chk("R13 rdata zero", rdata, 8'h00);
    chk("R13 no poll_clear", poll_clear, 0);
    cyc_end();
    rd_chk(0, 8'h02, "R13 poll still armed");
    best_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sel = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 8'h00;
    irr_in = 8'h55; isr_in = 8'h0A; best_valid = 0; best_line = 3'd0;
    ack_line = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_init_full();
    t_init_short();
    t_ctrl();
    t_cmd();
    t_poll();
    t_same_cycle();
    t_nosel();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule